// File: doc/BRIEF.md
# Register-Mapped Stream Packet Bridge

This block sits between a processor's 32-bit register bus (AXI4-Lite style, one outstanding access per direction) and a pair of AXI4-Stream ports. To send a packet, software stores words one at a time through a transmit data register and then writes a byte count. That count launches a single outgoing packet of count/4 words, and tlast marks its final word. Incoming stream packets go into a receive FIFO. The byte length of each packet is kept in a small length queue, so several packets can wait at once. Software reads the length of the oldest packet and then pops its words one by one through a receive data register.

Vacancy, occupancy and status registers let software avoid overrunning or underrunning the FIFOs. A write-one-to-clear interrupt register records transmit completion, packet arrival and access errors. The interrupt line is the OR of its bits. Register offsets are decoded from address bits [4:2]: 0x00 interrupt flags, 0x04 transmit vacancy, 0x08 transmit data, 0x0C transmit length, 0x10 receive occupancy, 0x14 receive data, 0x18 receive length, 0x1C status.

Top module: `mm_stream_bridge`

## Requirements
- R1: After an active-low reset, the interrupt register reads 0, transmit vacancy reads FIFO_DEPTH, receive occupancy reads 0, status reads 0xC, and txValid and irq are low.
- R2: A write to offset 0x08 appends the written word to the transmit FIFO and lowers vacancy (0x04) by one, without driving txValid.
- R3: A write of byte count L to offset 0x0C sends the oldest L/4 buffered words in write order as one packet. txLast is high only with the final word, and txValid, txData and txLast hold while txReady is low.
- R4: Interrupt bit 0 (transmit done) sets after the final word of a packet is accepted (txValid and txReady both high), and not before.
- R5: Words accepted on the receive stream raise the receive occupancy (0x10) by one each, and interrupt bit 1 sets when a word with rxLast is accepted.
- R6: A read of offset 0x18 returns the byte length (4 x word count) of the oldest unread packet and removes it from the length queue. When no length is queued, the read returns 0.
- R7: Each read of offset 0x14 pops and returns one received word, in arrival order.
- R8: A write to offset 0x00 clears exactly the interrupt bits written as 1. Writing all ones leaves the register reading 0.
- R9: A transmit data write while the transmit FIFO is full is dropped and sets interrupt bit 2. A receive data read while the receive FIFO is empty returns 0, leaves occupancy unchanged and sets interrupt bit 3.
- R10: rxReady is low while the receive FIFO is full or the length queue holds LEN_DEPTH entries.
- R11: irq is high exactly when any interrupt bit is set.
- R12: Status (0x1C) bit 0 is transmit busy, bit 1 transmit FIFO full, bit 2 receive FIFO empty, bit 3 length queue empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| awAddr | input | ADDR_W | Write address |
| awValid | input | 1 | Write address valid |
| awReady | output | 1 | Write address accepted |
| wData | input | 32 | Write data |
| wValid | input | 1 | Write data valid |
| wReady | output | 1 | Write data accepted |
| bValid | output | 1 | Write response valid |
| bReady | input | 1 | Write response taken |
| arAddr | input | ADDR_W | Read address |
| arValid | input | 1 | Read address valid |
| arReady | output | 1 | Read address accepted |
| rData | output | 32 | Read data |
| rValid | output | 1 | Read data valid |
| rReady | input | 1 | Read data taken |
| txData | output | 32 | Outgoing stream data |
| txValid | output | 1 | Outgoing stream valid |
| txReady | input | 1 | Outgoing stream ready |
| txLast | output | 1 | Final word of outgoing packet |
| rxData | input | 32 | Incoming stream data |
| rxValid | input | 1 | Incoming stream valid |
| rxReady | output | 1 | Incoming stream ready |
| rxLast | input | 1 | Final word of incoming packet |
| irq | output | 1 | Interrupt, OR of pending flags |

## Verification
The bench instantiates the bridge with FIFO_DEPTH set to 8 and LEN_DEPTH set to 4. With those sizes a few register writes fill the transmit FIFO, which brings the overrun drop and the full status bit within reach. A single eight-word packet stalls the receive stream on a full FIFO, and four one-word packets stall it on a full length queue. Random packet sizes and a randomly toggling txReady then exercise both directions repeatedly.

// File: rtl/mmsb_pkg.sv
package mmsb_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 16;

  localparam int IRQ_TX_DONE  = 0;
  localparam int IRQ_RX_PKT   = 1;
  localparam int IRQ_TX_OVER  = 2;
  localparam int IRQ_RX_UNDER = 3;
  localparam int IRQ_W        = 4;

  typedef struct packed {
    logic              txPush;
    logic              txStart;
    logic [CNT_W-1:0]  txWords;
    logic              rxPop;
    logic              lenPop;
    logic [WORD_W-1:0] wrWord;
  } strobe_t;

  typedef struct packed {
    logic [CNT_W-1:0]  txCount;
    logic [CNT_W-1:0]  rxCount;
    logic              txFull;
    logic              rxEmpty;
    logic              lenEmpty;
    logic              txBusy;
    logic              txDoneEv;
    logic              rxPktEv;
    logic [WORD_W-1:0] rxHead;
    logic [WORD_W-1:0] lenHead;
  } dpStat_t;
endpackage

// File: rtl/mmsb_fifo.sv
module mmsb_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 512,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9: occupancy never exceeds the storage
  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  // R9: a push into a full FIFO without a pop leaves the count alone
  p_full_push_r9: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> (count == $past(count)));
endmodule

// File: rtl/mmsb_datapath.sv
module mmsb_datapath
  import mmsb_pkg::*;
#(
  parameter int FIFO_DEPTH = 512,
  parameter int LEN_DEPTH  = 16,
  localparam int FCNT_W = $clog2(FIFO_DEPTH + 1),
  localparam int LCNT_W = $clog2(LEN_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  output dpStat_t           stat,
  output logic [WORD_W-1:0] txData,
  output logic              txValid,
  input  logic              txReady,
  output logic              txLast,
  input  logic [WORD_W-1:0] rxData,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic              rxLast
);
  logic [FCNT_W-1:0] txCnt, rxCnt;
  logic [LCNT_W-1:0] lenCnt;
  logic txFull, txEmpty, rxFull, rxEmpty, lenFull, lenEmpty;
  logic [WORD_W-1:0] txHead, rxHead, lenHead, lenWord;
  logic txFire, rxFire, lenPush;
  logic busy;
  logic [CNT_W-1:0] remaining, pktWords;

  assign txFire  = txValid && txReady;
  assign txValid = busy && !txEmpty;
  assign txLast  = busy && (remaining == CNT_W'(1));
  assign txData  = txHead;

  mmsb_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txFifo (
    .clk, .rstN, .push(st.txPush), .pushData(st.wrWord), .pop(txFire),
    .head(txHead), .count(txCnt), .full(txFull), .empty(txEmpty));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      remaining <= '0;
    end else if (busy) begin
      if (txFire) begin
        remaining <= remaining - 1'b1;
        if (remaining == CNT_W'(1)) busy <= 1'b0;
      end
    end else if (st.txStart && st.txWords != '0) begin
      busy      <= 1'b1;
      remaining <= st.txWords;
    end
  end

  assign rxReady = !rxFull && !lenFull;
  assign rxFire  = rxValid && rxReady;
  assign lenPush = rxFire && rxLast;
  assign lenWord = {{(WORD_W - CNT_W){1'b0}}, pktWords + 1'b1} << 2;

  always_ff @(posedge clk) begin
    if (!rstN)       pktWords <= '0;
    else if (lenPush) pktWords <= '0;
    else if (rxFire)  pktWords <= pktWords + 1'b1;
  end

  mmsb_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxFifo (
    .clk, .rstN, .push(rxFire), .pushData(rxData), .pop(st.rxPop),
    .head(rxHead), .count(rxCnt), .full(rxFull), .empty(rxEmpty));

  mmsb_fifo #(.WIDTH(WORD_W), .DEPTH(LEN_DEPTH)) u_lenFifo (
    .clk, .rstN, .push(lenPush), .pushData(lenWord), .pop(st.lenPop),
    .head(lenHead), .count(lenCnt), .full(lenFull), .empty(lenEmpty));

  always_comb begin
    stat          = '0;
    stat.txCount  = CNT_W'(txCnt);
    stat.rxCount  = CNT_W'(rxCnt);
    stat.txFull   = txFull;
    stat.rxEmpty  = rxEmpty;
    stat.lenEmpty = lenEmpty;
    stat.txBusy   = busy;
    stat.txDoneEv = txFire && txLast;
    stat.rxPktEv  = lenPush;
    stat.rxHead   = rxHead;
    stat.lenHead  = lenHead;
  end

  // R3: a stalled outgoing word is held unchanged
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData) && $stable(txLast)));
  // R4: accepting the final word ends the packet
  p_last_ends_r4: assert property (@(posedge clk) disable iff (!rstN)
    (txFire && txLast) |=> !busy);
  // R10: no word is accepted into a full receive FIFO
  p_rx_no_over_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxFull) |=> (rxCnt <= $past(rxCnt)));
endmodule

// File: rtl/mmsb_ctrl.sv
module mmsb_ctrl
  import mmsb_pkg::*;
#(
  parameter int FIFO_DEPTH = 512,
  parameter int ADDR_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic              awValid,
  output logic              awReady,
  input  logic [WORD_W-1:0] wData,
  input  logic              wValid,
  output logic              wReady,
  output logic              bValid,
  input  logic              bReady,
  input  logic [ADDR_W-1:0] arAddr,
  input  logic              arValid,
  output logic              arReady,
  output logic [WORD_W-1:0] rData,
  output logic              rValid,
  input  logic              rReady,
  input  dpStat_t           stat,
  output strobe_t           st,
  output logic              irq
);
  typedef enum logic [2:0] {
    SEL_ISR = 3'd0, SEL_VAC = 3'd1, SEL_TXD = 3'd2, SEL_TXL = 3'd3,
    SEL_OCC = 3'd4, SEL_RXD = 3'd5, SEL_RXL = 3'd6, SEL_STA = 3'd7
  } regSel_e;

  logic wrGo, rdGo;
  regSel_e wrSel, rdSel;
  logic [IRQ_W-1:0] isr, events, clearMask;
  logic [WORD_W-1:0] rdMux;

  assign wrGo    = awValid && wValid && !bValid;
  assign awReady = wValid && !bValid;
  assign wReady  = awValid && !bValid;
  assign rdGo    = arValid && !rValid;
  assign arReady = !rValid;
  assign wrSel   = regSel_e'(awAddr[4:2]);
  assign rdSel   = regSel_e'(arAddr[4:2]);

  always_comb begin
    st         = '0;
    st.wrWord  = wData;
    st.txPush  = wrGo && wrSel == SEL_TXD && !stat.txFull;
    st.txStart = wrGo && wrSel == SEL_TXL;
    st.txWords = wData[CNT_W+1:2];
    st.rxPop   = rdGo && rdSel == SEL_RXD && !stat.rxEmpty;
    st.lenPop  = rdGo && rdSel == SEL_RXL && !stat.lenEmpty;
  end

  always_comb begin
    events = '0;
    events[IRQ_TX_DONE]  = stat.txDoneEv;
    events[IRQ_RX_PKT]   = stat.rxPktEv;
    events[IRQ_TX_OVER]  = wrGo && wrSel == SEL_TXD && stat.txFull;
    events[IRQ_RX_UNDER] = rdGo && rdSel == SEL_RXD && stat.rxEmpty;
    clearMask = (wrGo && wrSel == SEL_ISR) ? wData[IRQ_W-1:0] : '0;
  end

  always_comb begin
    case (rdSel)
      SEL_ISR: rdMux = {{(WORD_W - IRQ_W){1'b0}}, isr};
      SEL_VAC: rdMux = WORD_W'(FIFO_DEPTH) - {{(WORD_W - CNT_W){1'b0}}, stat.txCount};
      SEL_OCC: rdMux = {{(WORD_W - CNT_W){1'b0}}, stat.rxCount};
      SEL_RXD: rdMux = stat.rxEmpty ? '0 : stat.rxHead;
      SEL_RXL: rdMux = stat.lenEmpty ? '0 : stat.lenHead;
      SEL_STA: rdMux = {{(WORD_W - 4){1'b0}}, stat.lenEmpty, stat.rxEmpty,
                        stat.txFull, stat.txBusy};
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isr    <= '0;
      bValid <= 1'b0;
      rValid <= 1'b0;
      rData  <= '0;
    end else begin
      isr <= (isr & ~clearMask) | events;
      if (wrGo)        bValid <= 1'b1;
      else if (bReady) bValid <= 1'b0;
      if (rdGo) begin
        rValid <= 1'b1;
        rData  <= rdMux;
      end else if (rReady) begin
        rValid <= 1'b0;
      end
    end
  end

  assign irq = |isr;

  // bus handshake: a pending response stays until taken
  p_bvalid_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (bValid && !bReady) |=> bValid);
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rValid && !rReady) |=> (rValid && $stable(rData)));
  // R8: an all-ones clear with no new event empties the flags
  p_isr_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrGo && wrSel == SEL_ISR && (&wData[IRQ_W-1:0]) && events == '0) |=> (isr == '0));
endmodule

// File: rtl/mm_stream_bridge.sv
module mm_stream_bridge
  import mmsb_pkg::*;
#(
  parameter int FIFO_DEPTH = 512,
  parameter int LEN_DEPTH  = 16,
  parameter int ADDR_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] awAddr,
  input  logic              awValid,
  output logic              awReady,
  input  logic [31:0]       wData,
  input  logic              wValid,
  output logic              wReady,
  output logic              bValid,
  input  logic              bReady,
  input  logic [ADDR_W-1:0] arAddr,
  input  logic              arValid,
  output logic              arReady,
  output logic [31:0]       rData,
  output logic              rValid,
  input  logic              rReady,
  output logic [31:0]       txData,
  output logic              txValid,
  input  logic              txReady,
  output logic              txLast,
  input  logic [31:0]       rxData,
  input  logic              rxValid,
  output logic              rxReady,
  input  logic              rxLast,
  output logic              irq
);
  strobe_t st;
  dpStat_t stat;

  mmsb_ctrl #(.FIFO_DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk, .rstN, .awAddr, .awValid, .awReady, .wData, .wValid, .wReady,
    .bValid, .bReady, .arAddr, .arValid, .arReady, .rData, .rValid, .rReady,
    .stat, .st, .irq);

  mmsb_datapath #(.FIFO_DEPTH(FIFO_DEPTH), .LEN_DEPTH(LEN_DEPTH)) u_dp (
    .clk, .rstN, .st, .stat, .txData, .txValid, .txReady, .txLast,
    .rxData, .rxValid, .rxReady, .rxLast);
endmodule

// File: tb/sim_mm_stream_bridge.sv
module sim_mm_stream_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int LDEPTH = 4;
  localparam logic [4:0] A_ISR = 5'h00, A_VAC = 5'h04, A_TXD = 5'h08, A_TXL = 5'h0C,
                         A_OCC = 5'h10, A_RXD = 5'h14, A_RXL = 5'h18, A_STA = 5'h1C;

  logic clk = 0, rstN = 0;
  logic [4:0] awAddr = 0, arAddr = 0;
  logic awValid = 0, wValid = 0, arValid = 0, bReady = 1, rReady = 1;
  logic awReady, wReady, bValid, arReady, rValid, irq;
  logic [31:0] wData = 0, rData, txData, rxData = 0;
  logic txValid, txReady = 0, txLast, rxValid = 0, rxReady, rxLast = 0;

  int checks = 0, failures = 0, sinkMode = 0, capCount = 0;
  logic [31:0] capData [256];
  logic capLast [256];
  logic [31:0] txModel [$];
  logic [31:0] rxModel [$];
  logic [31:0] v;

  always #(CLK_PERIOD/2) clk = ~clk;

  mm_stream_bridge #(.FIFO_DEPTH(DEPTH), .LEN_DEPTH(LDEPTH), .ADDR_W(5)) u0 (.*);

  initial forever begin
    @(posedge clk); #1;
    txReady = (sinkMode == 2) ? 1'b1 : (sinkMode == 1) ? 1'($urandom % 2) : 1'b0;
  end

  always @(negedge clk) if (txValid && txReady && capCount < 256) begin
    capData[capCount] = txData;
    capLast[capCount] = txLast;
    capCount++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [4:0] a, logic [31:0] d);
    @(negedge clk); awAddr = a; wData = d; awValid = 1; wValid = 1; #1;
    while (!(awReady && wReady)) begin @(negedge clk); #1; end
    @(negedge clk); awValid = 0; wValid = 0;
  endtask

  task automatic busRead(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); arAddr = a; arValid = 1; #1;
    while (!arReady) begin @(negedge clk); #1; end
    @(negedge clk); arValid = 0; d = rData;
  endtask

  task automatic readChk(string req, logic [4:0] a, logic [31:0] exp);
    logic [31:0] d;
    busRead(a, d);
    chk(req, d, exp);
  endtask

  task automatic sendPkt(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rxValid = 1; rxData = $urandom; rxLast = (i == n - 1); #1;
      while (!rxReady) begin @(negedge clk); #1; end
      rxModel.push_back(rxData);
      @(posedge clk);
    end
    @(negedge clk); rxValid = 0; rxLast = 0;
  endtask

  task automatic pushTx(int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] w = $urandom;
      busWrite(A_TXD, w);
      txModel.push_back(w);
    end
  endtask

  task automatic waitCap(int n);
    int t = 0;
    while (capCount < n && t < 2000) begin @(negedge clk); t++; end
  endtask

  // checks a finished packet of n words, R3 order and last flag
  task automatic checkPkt(int n);
    waitCap(n);
    chk("R3 word count", capCount, n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] e = txModel.pop_front();
      chk("R3 data", capData[i], e);
      chk("R3 last", 32'(capLast[i]), 32'(i == n - 1));
    end
    capCount = 0;
  endtask

  task automatic drainPkt(int n);
    readChk("R6 length", A_RXL, 32'(n * 4));
    for (int i = 0; i < n; i++) readChk("R7 word", A_RXD, rxModel.pop_front());
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk("R1 txValid", 32'(txValid), 0);
    chk("R1 irq", 32'(irq), 0);
    readChk("R1 isr", A_ISR, 0);
    readChk("R1 vacancy", A_VAC, DEPTH);
    readChk("R1 occupancy", A_OCC, 0);
    readChk("R1 status", A_STA, 32'hC);

    // R2 buffering without output
    sinkMode = 2;
    pushTx(3);
    repeat (5) @(negedge clk);
    chk("R2 no stream output", capCount, 0);
    readChk("R2 vacancy", A_VAC, DEPTH - 3);
    readChk("R12 status idle", A_STA, 32'hC);

    // R3 launch, R4 done, R11 irq, R8 clear
    sinkMode = 1;
    busWrite(A_TXL, 12);
    checkPkt(3);
    readChk("R4 done flag", A_ISR, 1);
    chk("R11 irq high", 32'(irq), 1);
    busWrite(A_ISR, 32'hFFFF_FFFF);
    readChk("R8 cleared", A_ISR, 0);
    chk("R11 irq low", 32'(irq), 0);

    // R12 busy, R4 not done while stalled
    sinkMode = 0;
    pushTx(2);
    busWrite(A_TXL, 8);
    repeat (3) @(negedge clk);
    readChk("R12 busy", A_STA, 32'hD);
    readChk("R4 not done yet", A_ISR, 0);
    sinkMode = 2;
    checkPkt(2);
    readChk("R4 done after last", A_ISR, 1);
    busWrite(A_ISR, 32'hF);

    // R9 transmit overrun
    pushTx(DEPTH);
    busWrite(A_TXD, 32'hDEAD_BEEF);
    readChk("R9 vacancy zero", A_VAC, 0);
    readChk("R12 full", A_STA, 32'hE);
    readChk("R9 overrun flag", A_ISR, 4);
    sinkMode = 1;
    busWrite(A_TXL, DEPTH * 4);
    checkPkt(DEPTH);
    readChk("R2 vacancy back", A_VAC, DEPTH);
    readChk("R9 flags", A_ISR, 5);
    busWrite(A_ISR, 4);
    readChk("R8 selective clear", A_ISR, 1);
    busWrite(A_ISR, 32'hFFFF_FFFF);

    // R9 receive underrun
    readChk("R9 empty read", A_RXD, 0);
    readChk("R9 occupancy", A_OCC, 0);
    readChk("R9 underrun flag", A_ISR, 8);
    busWrite(A_ISR, 32'hF);

    // R5 R6 R7 two pending packets
    sendPkt(3);
    sendPkt(2);
    readChk("R5 occupancy", A_OCC, 5);
    readChk("R5 packet flag", A_ISR, 2);
    drainPkt(3);
    drainPkt(2);
    readChk("R6 empty length", A_RXL, 0);
    readChk("R5 occupancy drained", A_OCC, 0);
    readChk("R12 status empty", A_STA, 32'hC);

    // R10 full receive FIFO
    sendPkt(DEPTH);
    @(negedge clk); rxValid = 1; rxData = 32'h1234; rxLast = 1; #1;
    chk("R10 stall on full fifo", 32'(rxReady), 0);
    repeat (3) @(negedge clk);
    rxValid = 0; rxLast = 0;
    readChk("R10 occupancy held", A_OCC, DEPTH);
    drainPkt(DEPTH);

    // R10 full length queue
    for (int p = 0; p < LDEPTH; p++) sendPkt(1);
    @(negedge clk); rxValid = 1; rxLast = 1; #1;
    chk("R10 stall on full length queue", 32'(rxReady), 0);
    @(negedge clk); rxValid = 0; rxLast = 0;
    readChk("R10 occupancy", A_OCC, LDEPTH);
    for (int p = 0; p < LDEPTH; p++) drainPkt(1);
    busWrite(A_ISR, 32'hF);

    // random rounds
    for (int r = 0; r < 20; r++) begin
      int n = 1 + $urandom % DEPTH;
      int k = 1 + $urandom % 3;
      int lens [3];
      sinkMode = 1;
      pushTx(n);
      busWrite(A_TXL, 32'(n * 4));
      checkPkt(n);
      for (int p = 0; p < k; p++) begin lens[p] = 1 + $urandom % 2; sendPkt(lens[p]); end
      for (int p = 0; p < k; p++) drainPkt(lens[p]);
      readChk("R1 flags then clear", A_ISR, 3);
      busWrite(A_ISR, 32'hF);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule